// File: doc/BRIEF.md
# Step Attenuator Serial Word Loader

This block runs on the host side of a digitally controlled RF step attenuator whose control port is a three-wire serial link: a data line, a serial clock and a latch strobe. A client hands the block a 6-bit attenuation code over a valid/ready handshake. The block then shifts the code out with the most significant bit first, which is the 16 dB weight, and ends with the 0.5 dB weight. It latches the code into the attenuator with one strobe pulse. It then reports completion and stays busy long enough to keep the attenuator's update rate under its limit.

Every timing interval is a count of system-clock cycles set by a parameter. This covers data setup before a rising serial clock, clock high time, data hold after a falling edge, strobe delay after the last falling edge, strobe width and the minimum gap between updates. Each count is at least 1. With a 50 MHz system clock the defaults give at least 40 ns for each interval. The default gap of 2000 cycles is 40 µs, which holds the update rate at 25 kHz or below. The serial clock runs at no more than 10 MHz.

The sequencer is one state machine. Its states are ST_IDLE, ST_SETUP, ST_SCLK_HI, ST_HOLD, ST_LE_WAIT, ST_LE_HI and ST_GAP. Its transitions are:
- accept: ST_IDLE to ST_SETUP.
- rise: ST_SETUP to ST_SCLK_HI.
- fall: ST_SCLK_HI to ST_HOLD.
- next-bit: ST_HOLD to ST_SETUP.
- last-bit: ST_HOLD to ST_LE_WAIT.
- strobe: ST_LE_WAIT to ST_LE_HI.
- latch: ST_LE_HI to ST_GAP.
- release: ST_GAP to ST_IDLE.

Every state except ST_IDLE lasts exactly its parameter's number of cycles. All outputs are registered.

Top module: `atten_serial_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, ser_clk_o, ser_le_o, ser_data_o and done_o are 0, and ready_o is 1.
- R2: A code accepted when valid_i and ready_o are both 1 at a rising clk edge is sent as exactly six serial clock pulses. The bit present on ser_data_o during the k-th pulse (k = 0..5) is word_i[5-k], so bit 5 (16 dB) goes first and bit 0 (0.5 dB) goes last.
- R3: Each serial clock high phase lasts CLK_HI_CYC cycles. The first rising edge comes SETUP_CYC cycles after acceptance. Successive rising edges are SETUP_CYC+CLK_HI_CYC+HOLD_CYC cycles apart.
- R4: ser_data_o takes a bit's value SETUP_CYC cycles before that bit's rising edge. It keeps that value through the high phase and for HOLD_CYC cycles after the falling edge.
- R5: ser_le_o is 0 while bits are shifted. It rises LE_SETUP_CYC cycles after the last falling edge and stays high for LE_HI_CYC cycles, once per transfer, never together with ser_clk_o.
- R6: done_o is a one-cycle pulse in the first cycle after ser_le_o falls.
- R7: ready_o drops in the cycle after acceptance. It returns GAP_CYC cycles after ser_le_o falls.
- R8: valid_i and word_i are ignored while ready_o is 0. The serial bits, clock and strobe of the transfer in progress do not change.
- R9: While ready_o is 1, ser_clk_o, ser_le_o and ser_data_o are all 0, including when valid_i is held low for many cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_i | input | 6 | Attenuation code, bit 5 = 16 dB ... bit 0 = 0.5 dB |
| valid_i | input | 1 | Code request |
| ready_o | output | 1 | Block can accept a code |
| done_o | output | 1 | One-cycle pulse after the latch strobe |
| ser_clk_o | output | 1 | Serial clock to the attenuator |
| ser_data_o | output | 1 | Serial data to the attenuator |
| ser_le_o | output | 1 | Latch strobe to the attenuator |

## Verification
Every output is a register that follows the sequencer state, so each result has a fixed offset from the acceptance edge. With per-bit period P = SETUP_CYC+CLK_HI_CYC+HOLD_CYC:
- Bit k's data is due 1 cycle after acceptance plus k·P.
- Its clock high phase is due SETUP_CYC cycles later.
- The strobe rises 6·P+LE_SETUP_CYC+1 cycles after acceptance.
- done_o appears LE_HI_CYC cycles after the strobe rises.
- ready_o returns GAP_CYC cycles after done_o.

The bench numbers the cycles after acceptance. It samples every output on the falling clk edge of each numbered cycle and compares them all against a function of that cycle number and the accepted code. No result is checked at any other offset. Random codes, some with valid_i and a different code held during the busy period, are mixed with all-zero, all-one and single-bit codes.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SCLK_HI,
        ST_HOLD,
        ST_LE_WAIT,
        ST_LE_HI,
        ST_GAP
    } ser_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_bit_state(input ser_state_e s);
        return (s == ST_SETUP) || (s == ST_SCLK_HI) || (s == ST_HOLD);
    endfunction

endpackage

// File: rtl/atten_ser_timer.sv
module atten_ser_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          zero_o
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

    // R3
    timer_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && zero_o) |=> zero_o);

endmodule

// File: rtl/atten_ser_shifter.sv
module atten_ser_shifter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] word_i,
    output logic         next_msb_o,
    output logic         last_o
);

    localparam int BW = (W > 2) ? $clog2(W) : 1;

    logic [W-1:0]  sh_q, sh_nx;
    logic [BW-1:0] left_q, left_nx;

    always_comb begin
        sh_nx   = sh_q;
        left_nx = left_q;
        if (load_i) begin
            sh_nx   = word_i;
            left_nx = BW'(W - 1);
        end else if (shift_i) begin
            sh_nx   = {sh_q[W-2:0], 1'b0};
            left_nx = left_q - BW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else begin
            sh_q   <= sh_nx;
            left_q <= left_nx;
        end
    end

    assign next_msb_o = sh_nx[W-1];
    assign last_o     = (left_q == '0);

    // R2
    shift_not_past_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |-> !last_o);

endmodule

// File: rtl/atten_ser_fsm.sv
module atten_ser_fsm
    import atten_ser_pkg::*;
#(
    parameter int TW          = 11,
    parameter int SETUP_CYC   = 2,
    parameter int CLK_HI_CYC  = 2,
    parameter int HOLD_CYC    = 2,
    parameter int LE_SETUP_CYC = 2,
    parameter int LE_HI_CYC   = 2,
    parameter int GAP_CYC     = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic          tmr_zero_i,
    input  logic          last_bit_i,
    input  logic          next_msb_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output logic          sh_load_o,
    output logic          sh_shift_o,
    output logic          ready_o,
    output logic          done_o,
    output logic          sclk_o,
    output logic          sdata_o,
    output logic          le_o
);

    localparam logic [TW-1:0] SETUP_LD = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] HI_LD    = TW'(CLK_HI_CYC - 1);
    localparam logic [TW-1:0] HOLD_LD  = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] LEW_LD   = TW'(LE_SETUP_CYC - 1);
    localparam logic [TW-1:0] LEH_LD   = TW'(LE_HI_CYC - 1);
    localparam logic [TW-1:0] GAP_LD   = TW'(GAP_CYC - 1);

    ser_state_e st_q, st_nx;
    logic ready_q, done_q, sclk_q, sdata_q, le_q;

    // next-state and control decode
    always_comb begin
        st_nx      = st_q;
        sh_load_o  = 1'b0;
        sh_shift_o = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (valid_i) begin
                    st_nx     = ST_SETUP;      // accept
                    sh_load_o = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_zero_i) st_nx = ST_SCLK_HI;  // rise
            end
            ST_SCLK_HI: begin
                if (tmr_zero_i) st_nx = ST_HOLD;     // fall
            end
            ST_HOLD: begin
                if (tmr_zero_i) begin
                    if (last_bit_i) begin
                        st_nx = ST_LE_WAIT;           // last-bit
                    end else begin
                        st_nx      = ST_SETUP;        // next-bit
                        sh_shift_o = 1'b1;
                    end
                end
            end
            ST_LE_WAIT: begin
                if (tmr_zero_i) st_nx = ST_LE_HI;    // strobe
            end
            ST_LE_HI: begin
                if (tmr_zero_i) st_nx = ST_GAP;      // latch
            end
            ST_GAP: begin
                if (tmr_zero_i) st_nx = ST_IDLE;     // release
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // interval count for the state being entered
    always_comb begin
        tmr_load_o = (st_nx != st_q);
        unique case (st_nx)
            ST_SETUP:   tmr_val_o = SETUP_LD;
            ST_SCLK_HI: tmr_val_o = HI_LD;
            ST_HOLD:    tmr_val_o = HOLD_LD;
            ST_LE_WAIT: tmr_val_o = LEW_LD;
            ST_LE_HI:   tmr_val_o = LEH_LD;
            ST_GAP:     tmr_val_o = GAP_LD;
            default:    tmr_val_o = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // registered outputs, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= 1'b1;
            done_q  <= 1'b0;
            sclk_q  <= 1'b0;
            sdata_q <= 1'b0;
            le_q    <= 1'b0;
        end else begin
            ready_q <= (st_nx == ST_IDLE);
            done_q  <= (st_q == ST_LE_HI) && (st_nx == ST_GAP);
            sclk_q  <= (st_nx == ST_SCLK_HI);
            sdata_q <= is_bit_state(st_nx) ? next_msb_i : 1'b0;
            le_q    <= (st_nx == ST_LE_HI);
        end
    end

    assign ready_o = ready_q;
    assign done_o  = done_q;
    assign sclk_o  = sclk_q;
    assign sdata_o = sdata_q;
    assign le_o    = le_q;

    // R5
    le_without_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le_q |-> !sclk_q);

    // R6
    done_after_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(le_q) && !le_q));

    // R7
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q || le_q || done_q) |-> !ready_q);

    // R4
    data_stable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> $stable(sdata_q));

    // R4
    data_stable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_q) |-> $stable(sdata_q));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |-> (!sclk_q && !le_q && !sdata_q));

    // R8
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_q && $past(!ready_q) && $stable(st_q) && !tmr_zero_i) |=> $stable(sdata_q));

endmodule

// File: rtl/atten_serial_ctrl.sv
module atten_serial_ctrl
    import atten_ser_pkg::*;
#(
    parameter int WORD_W       = 6,
    parameter int SETUP_CYC    = 2,
    parameter int CLK_HI_CYC   = 2,
    parameter int HOLD_CYC     = 2,
    parameter int LE_SETUP_CYC = 2,
    parameter int LE_HI_CYC    = 2,
    parameter int GAP_CYC      = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic              done_o,
    output logic              ser_clk_o,
    output logic              ser_data_o,
    output logic              ser_le_o
);

    localparam int MAX_CYC = max_of(max_of(max_of(SETUP_CYC, CLK_HI_CYC), max_of(HOLD_CYC, LE_SETUP_CYC)),
                                    max_of(LE_HI_CYC, GAP_CYC));
    localparam int TW = (MAX_CYC > 1) ? $clog2(MAX_CYC + 1) : 1;

    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          sh_load, sh_shift, next_msb, last_bit;

    atten_ser_timer #(.TW(TW)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    atten_ser_shifter #(.W(WORD_W)) shifter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sh_load),
        .shift_i    (sh_shift),
        .word_i     (word_i),
        .next_msb_o (next_msb),
        .last_o     (last_bit)
    );

    atten_ser_fsm #(
        .TW           (TW),
        .SETUP_CYC    (SETUP_CYC),
        .CLK_HI_CYC   (CLK_HI_CYC),
        .HOLD_CYC     (HOLD_CYC),
        .LE_SETUP_CYC (LE_SETUP_CYC),
        .LE_HI_CYC    (LE_HI_CYC),
        .GAP_CYC      (GAP_CYC)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (valid_i),
        .tmr_zero_i (tmr_zero),
        .last_bit_i (last_bit),
        .next_msb_i (next_msb),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .sh_load_o  (sh_load),
        .sh_shift_o (sh_shift),
        .ready_o    (ready_o),
        .done_o     (done_o),
        .sclk_o     (ser_clk_o),
        .sdata_o    (ser_data_o),
        .le_o       (ser_le_o)
    );

endmodule

// File: tb/atten_serial_ctrl_tb.sv
module atten_serial_ctrl_tb_top;

    localparam int S = 2;
    localparam int H = 2;
    localparam int D = 1;
    localparam int L = 2;
    localparam int Q = 3;
    localparam int G = 50;
    localparam int P = S + H + D;
    localparam int T_LE   = 6 * P + L + 1;
    localparam int T_DONE = 6 * P + L + Q + 1;
    localparam int T_END  = 6 * P + L + Q + G + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] word = '0;
    logic       valid = 1'b0;
    logic       ready, done, sclk, sdata, le;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    atten_serial_ctrl #(
        .WORD_W(6), .SETUP_CYC(S), .CLK_HI_CYC(H), .HOLD_CYC(D),
        .LE_SETUP_CYC(L), .LE_HI_CYC(Q), .GAP_CYC(G)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .word_i(word), .valid_i(valid),
        .ready_o(ready), .done_o(done), .ser_clk_o(sclk),
        .ser_data_o(sdata), .ser_le_o(le)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0b exp=%0b at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // expected {sclk, le, sdata, done, ready} for cycle t after acceptance
    function automatic logic [4:0] exp_out(input int t, input logic [5:0] w);
        logic [4:0] e;
        e = 5'b0;
        if (t >= 1 && t <= 6 * P) begin
            int k   = (t - 1) / P;
            int off = (t - 1) % P;
            e[4] = (off >= S) && (off < S + H);
            e[2] = w[5 - k];
        end else if (t >= T_LE && t < T_DONE) begin
            e[3] = 1'b1;
        end
        if (t == T_DONE) e[1] = 1'b1;
        if (t >= T_END) e[0] = 1'b1;
        return e;
    endfunction

    task automatic check_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R9", "idle ser_clk", sclk, 1'b0);
            chk("R9", "idle ser_le", le, 1'b0);
            chk("R9", "idle ser_data", sdata, 1'b0);
            chk("R9", "idle ready", ready, 1'b1);
        end
    endtask

    task automatic run_xfer(input logic [5:0] w, input logic noisy);
        logic [4:0] e;
        @(negedge clk);
        word  = w;
        valid = 1'b1;
        for (int t = 1; t <= T_END; t++) begin
            @(negedge clk);
            if (noisy && t < T_END) begin
                valid = 1'b1;
                word  = ~w ^ 6'($urandom_range(0, 63));
            end else begin
                valid = 1'b0;
            end
            e = exp_out(t, w);
            chk("R3", "ser_clk", sclk, e[4]);
            chk("R5", "ser_le", le, e[3]);
            chk(noisy ? "R8" : ((t - 1) % P == S ? "R2" : "R4"), "ser_data", sdata, e[2]);
            chk("R6", "done", done, e[1]);
            chk("R7", "ready", ready, e[0]);
        end
        valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        valid = 1'b1;
        word  = 6'h3F;
        repeat (3) @(negedge clk);
        // R1 during reset, valid ignored
        chk("R1", "reset ser_clk", sclk, 1'b0);
        chk("R1", "reset ser_le", le, 1'b0);
        chk("R1", "reset ser_data", sdata, 1'b0);
        chk("R1", "reset done", done, 1'b0);
        chk("R1", "reset ready", ready, 1'b1);
        valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "post-reset ready", ready, 1'b1);
        chk("R1", "post-reset done", done, 1'b0);
        check_idle(10);

        // directed corner codes (R2 bit order)
        run_xfer(6'h00, 1'b0);
        run_xfer(6'h3F, 1'b0);
        run_xfer(6'h20, 1'b0);
        run_xfer(6'h01, 1'b0);
        run_xfer(6'h2A, 1'b0);
        run_xfer(6'h15, 1'b1);
        check_idle(5);

        for (int i = 0; i < 40; i++) begin
            run_xfer(6'($urandom_range(0, 63)), 1'($urandom_range(0, 1)));
            if ((i % 8) == 0) check_idle(3);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule